// File: doc/BRIEF.md
# Non-posted request credit counter

This block keeps count of how many non-posted requests the user logic downstream can still take. Each cycle the user logic may grant credit on a 2-bit code, and the request scheduler reports how many non-posted requests it hands over in that same cycle. The block folds both into a saturating credit count. It tells the scheduler through a single flag whether at least one credit is held. It also shows the count to the user logic on a 6-bit output, which trails the internal count by a configurable number of register stages.

A grant and a delivery in the same cycle do not cancel each other. Credit is added only in a cycle with no delivery, and credit is taken only in a cycle with no grant. Every other mix of the two inputs leaves the count unchanged. A user that does not want to hold back non-posted traffic can keep the grant code at 2'b11. The grant input has no timing link to packet boundaries.

Top module: `np_credit_tracker`

## Requirements
- R1: While rst_ni is low, and after its release until the first update, `count_o` reads 0 and `credit_avail_o` reads 0.
- R2: With `grant_i` = 2'b01 and `deliver_i` = 2'b00, the internal count grows by 1.
- R3: With `grant_i` = 2'b10 or 2'b11 and `deliver_i` = 2'b00, the internal count grows by 2.
- R4: The count never exceeds 32 (CREDIT_MAX). An increment that would pass 32 stops at 32, so 31 plus a grant of two gives 32.
- R5: With `grant_i` = 2'b00 and `deliver_i` = 2'b01 (one request delivered), the count drops by 1, but not below 0.
- R6: With `grant_i` = 2'b00 and `deliver_i` = 2'b10 (two requests delivered; code 2'b11 is treated the same), the count drops by 2, clamped at 0.
- R7: When `grant_i` and `deliver_i` are both non-zero, or both zero, the count is unchanged.
- R8: `credit_avail_o` is 1 exactly when the internal count is above 0. It follows the internal count in the cycle after the clock edge that updates it, with no extra delay.
- R9: `count_o` equals the internal count as it stood OUT_STAGES clock edges earlier (default 2). Its stages reset to 0.
- R10: While `grant_i` is held non-zero, deliveries never lower the count. A grant held at 2'b11 drives the count to 32 and keeps it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 2 | Credit grant code: 00 none, 01 one, 10/11 two |
| deliver_i | input | 2 | Non-posted requests delivered this cycle: 00 none, 01 one, 10/11 two |
| count_o | output | 6 | Credit count for the user, delayed by OUT_STAGES cycles |
| credit_avail_o | output | 1 | High when at least one credit is held |

## Verification
A bad internal count shows up on `credit_avail_o` one cycle after the faulty update, but only if it crosses zero. Otherwise it goes unseen there. On `count_o` any wrong value appears exactly OUT_STAGES cycles after the edge that produced it, and it persists until saturation or clamping at 0 masks it. Long random runs therefore have to pass through both 0 and 32 often. Directed cases pin the grant-of-two step from 31 and the two-request drop from 1.

// File: rtl/np_credit_pkg.sv
package np_credit_pkg;

  typedef logic [1:0] code_t;

  // grant code -> credits added
  function automatic logic [1:0] grant_amt(code_t g);
    case (g)
      2'b00:   grant_amt = 2'd0;
      2'b01:   grant_amt = 2'd1;
      default: grant_amt = 2'd2;
    endcase
  endfunction

  // delivery code -> credits consumed
  function automatic logic [1:0] deliver_amt(code_t d);
    case (d)
      2'b00:   deliver_amt = 2'd0;
      2'b01:   deliver_amt = 2'd1;
      default: deliver_amt = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/np_credit_step.sv
module np_credit_step
  import np_credit_pkg::*;
#(
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned CREDIT_MAX = 32
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  code_t            grant_i,
  input  code_t            deliver_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W:0] LIM = (CNT_W + 1)'(CREDIT_MAX);

  logic [1:0]       inc, dec;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] dec_w;

  assign inc   = grant_amt(grant_i);
  assign dec   = deliver_amt(deliver_i);
  assign sum   = {1'b0, cnt_i} + {{(CNT_W - 1){1'b0}}, inc};
  assign dec_w = {{(CNT_W - 2){1'b0}}, dec};

  always_comb begin
    cnt_o = cnt_i;
    if (inc != 2'd0 && dec == 2'd0) begin
      cnt_o = (sum > LIM) ? LIM[CNT_W-1:0] : sum[CNT_W-1:0];
    end else if (inc == 2'd0 && dec != 2'd0) begin
      cnt_o = (cnt_i > dec_w) ? cnt_i - dec_w : '0;
    end
  end

endmodule

// File: rtl/np_credit_reg.sv
module np_credit_reg #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] d_i,
  output logic [CNT_W-1:0] q_o,
  output logic             nz_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

  assign nz_o = |q_o;

endmodule

// File: rtl/np_credit_delay.sv
module np_credit_delay #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] stg_q [STAGES];
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stg_q[i] <= '0;
        else if (i == 0) stg_q[i] <= d_i;
        else             stg_q[i] <= stg_q[(i == 0) ? 0 : i - 1];
      end
    end
    assign q_o = stg_q[STAGES-1];
  end

endmodule

// File: rtl/np_credit_tracker.sv
module np_credit_tracker
  import np_credit_pkg::*;
#(
  parameter int unsigned CREDIT_MAX = 32,
  parameter int unsigned OUT_STAGES = 2,
  parameter int unsigned CNT_W      = $clog2(CREDIT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       grant_i,
  input  logic [1:0]       deliver_i,
  output logic [CNT_W-1:0] count_o,
  output logic             credit_avail_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  np_credit_step #(.CNT_W(CNT_W), .CREDIT_MAX(CREDIT_MAX)) i_step (
    .cnt_i    (cnt_q),
    .grant_i  (grant_i),
    .deliver_i(deliver_i),
    .cnt_o    (cnt_d)
  );

  np_credit_reg #(.CNT_W(CNT_W)) i_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cnt_d),
    .q_o   (cnt_q),
    .nz_o  (credit_avail_o)
  );

  np_credit_delay #(.W(CNT_W), .STAGES(OUT_STAGES)) i_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cnt_q),
    .q_o   (count_o)
  );

endmodule

// File: rtl/np_credit_checker.sv
module np_credit_checker #(
  parameter int unsigned CREDIT_MAX = 32,
  parameter int unsigned CNT_W      = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       grant_i,
  input logic [1:0]       deliver_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic             credit_avail_o
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(CREDIT_MAX);

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);

  a_r2_inc_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i == 2'b01 && deliver_i == 2'b00 && cnt_q < LIM)
      |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r3_inc_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i[1] && deliver_i == 2'b00 && cnt_q + 2 <= LIM)
      |=> cnt_q == $past(cnt_q) + 2'd2);

  a_r5_dec_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i == 2'b00 && deliver_i == 2'b01 && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r6_dec_two_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i == 2'b00 && deliver_i[1] && cnt_q < 2) |=> cnt_q == '0);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i != 2'b00 && deliver_i != 2'b00) |=> $stable(cnt_q));

  a_r8_no_avail_stays_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!credit_avail_o && grant_i == 2'b00) |=> !credit_avail_o);

endmodule

bind np_credit_tracker np_credit_checker #(
  .CREDIT_MAX(CREDIT_MAX),
  .CNT_W     (CNT_W)
) i_np_credit_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .grant_i       (grant_i),
  .deliver_i     (deliver_i),
  .cnt_q         (cnt_q),
  .credit_avail_o(credit_avail_o)
);

// File: tb/test_np_credit_tracker.sv
module test_np_credit_tracker;

  localparam int CLK_P  = 10;
  localparam int MAXC   = 32;
  localparam int STAGES = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] grant_i = 2'b00;
  logic [1:0] deliver_i = 2'b00;
  logic [5:0] count_o;
  logic       credit_avail_o;

  int errors = 0;
  int checks = 0;
  int model = 0;
  int hist [STAGES+1];
  string tag_hist [STAGES+1];

  always #(CLK_P/2) clk_i = ~clk_i;

  np_credit_tracker #(.CREDIT_MAX(MAXC), .OUT_STAGES(STAGES)) i_np_credit_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .grant_i(grant_i), .deliver_i(deliver_i),
    .count_o(count_o), .credit_avail_o(credit_avail_o)
  );

  function automatic int next_cnt(int c, logic [1:0] g, logic [1:0] d);
    int inc = (g == 2'b00) ? 0 : (g == 2'b01) ? 1 : 2;
    int dec = (d == 2'b00) ? 0 : (d == 2'b01) ? 1 : 2;
    if (inc != 0 && dec == 0) return (c + inc > MAXC) ? MAXC : c + inc;
    if (inc == 0 && dec != 0) return (c > dec) ? c - dec : 0;
    return c;
  endfunction

  function automatic string rule_tag(int c, logic [1:0] g, logic [1:0] d);
    if (g != 2'b00 && d != 2'b00) return "R7/R10";
    if (g == 2'b00 && d == 2'b00) return "R7";
    if (g != 2'b00 && c + ((g == 2'b01) ? 1 : 2) > MAXC) return "R4";
    if (g == 2'b01) return "R2";
    if (g != 2'b00) return "R3";
    if (d == 2'b01) return "R5";
    return "R6";
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: check outputs, drive inputs, advance model at the edge
  task automatic step(logic [1:0] g, logic [1:0] d);
    @(negedge clk_i);
    chk({tag_hist[STAGES], " R9 count_o"}, int'(count_o), hist[STAGES]);
    chk("R8 credit_avail_o", int'(credit_avail_o), (model > 0) ? 1 : 0);
    grant_i   = g;
    deliver_i = d;
    @(posedge clk_i);
    for (int i = STAGES; i > 0; i--) begin
      hist[i]     = hist[i-1];
      tag_hist[i] = tag_hist[i-1];
    end
    tag_hist[0] = rule_tag(model, g, d);
    model       = next_cnt(model, g, d);
    hist[0]     = model;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i <= STAGES; i++) begin
      hist[i] = 0;
      tag_hist[i] = "R1";
    end
    repeat (3) @(negedge clk_i);
    chk("R1 count_o in reset", int'(count_o), 0);
    chk("R1 avail in reset", int'(credit_avail_o), 0);
    rst_ni = 1'b1;

    // R1 idle after reset
    repeat (3) step(2'b00, 2'b00);
    // R6 drop from empty clamps at 0
    step(2'b00, 2'b10);
    step(2'b00, 2'b01);
    // R2, R3
    step(2'b01, 2'b00);
    step(2'b10, 2'b00);
    step(2'b11, 2'b00);
    // R6 from 1: 5 -> 3 -> 1 -> 0
    step(2'b00, 2'b11);
    step(2'b00, 2'b10);
    step(2'b00, 2'b10);
    // R10 grant held at 11 with deliveries: climbs to 32 and stays
    for (int i = 0; i < 20; i++) step(2'b11, 2'b00);
    for (int i = 0; i < 6; i++) step(2'b11, 2'((i % 3) + 1));
    // R4: 32 -> 31, then +2 -> 32
    step(2'b00, 2'b01);
    step(2'b10, 2'b00);
    step(2'b01, 2'b00);
    // R5 drain to 0
    for (int i = 0; i < 34; i++) step(2'b00, 2'b01);
    repeat (STAGES + 1) step(2'b00, 2'b00);

    // random phases, biased toward grants or deliveries
    for (int ph = 0; ph < 40; ph++) begin
      int bias = $urandom % 3;
      for (int k = 0; k < 60; k++) begin
        logic [1:0] g, d;
        g = 2'($urandom % 4);
        d = 2'($urandom % 4);
        if (bias == 0 && ($urandom % 4) != 0) d = 2'b00;
        if (bias == 1 && ($urandom % 4) != 0) g = 2'b00;
        step(g, d);
      end
    end
    repeat (STAGES + 1) step(2'b00, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule